// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive-side DMA engine of an Ethernet MAC. It steps through a ring of two-word descriptors in memory. Each descriptor points at one receive buffer. Bytes from the incoming frame stream go into that buffer. When the buffer is finished, the engine writes back a status word and then returns the descriptor to software by setting its ownership flag. The address bits of the descriptor are kept unchanged when that flag is set.

The ring start address is sampled from `ring_base` when `rx_enable` rises. A descriptor whose wrap flag is set is the last one in the ring, and the engine goes back to the start address after it. A frame that is longer than one buffer continues into the next descriptor.

If a frame starts while the current descriptor still belongs to software, the engine takes in the whole frame, discards it and sets a sticky overrun flag. While it waits for such a descriptor, the engine keeps reading it again until software frees it. The memory port is a plain single-cycle request port, and read data arrives one cycle after `mem_re`.

Top module: `rx_desc_ring_writer`

## Requirements
- R1: Reset state and disabled state. While `rx_enable` is low, and from reset, `in_ready`, `mem_re`, `mem_we` and `overrun` are all low.
- R2: On each rising edge of `rx_enable`, the ring start address is taken from `ring_base` with bits 2:0 cleared. The next frame goes to the descriptor at that address, wherever the engine stopped before.
- R3: Descriptor word 0 (at the descriptor address) holds the buffer address in bits 31:2, the wrap flag in bit 1 and the ownership flag in bit 0 (1 = software owns it). The engine writes only into buffers whose descriptor it read with bit 0 clear. On write-back it stores the same bits 31:1 with bit 0 set.
- R4: The status word sits at descriptor address + 4. Its layout is: bit 15 = end of frame, bit 14 = start of frame, bits 13:0 = number of bytes in this buffer, all other bits zero. The status word is written first, with all four byte enables set, and word 0 is written in the next cycle.
- R5: The bytes of a frame are stored in order at buffer address + offset. There is one write per byte. `mem_be` is one-hot on lane (offset mod 4), `mem_addr` is word aligned, and the byte is copied into all four lanes of `mem_wdata`.
- R6: A buffer holds `BUF_BYTES` bytes. A longer frame continues in the next descriptor. Only the first descriptor of the frame carries start of frame, and only the last one carries end of frame.
- R7: After a descriptor with the wrap flag set, the next descriptor is at the ring start address. Otherwise the next descriptor is at the current address + 8.
- R8: If a frame starts while the current descriptor is owned by software, every byte of that frame is accepted and discarded, and no memory is written. `overrun` goes high and stays high while `rx_enable` is high. It clears when `rx_enable` is low.
- R9: A byte offered outside a frame (`in_sof` low and no frame open) is accepted and discarded. It writes nothing and does not count toward any buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Receiver enable; rising edge loads the ring start |
| ring_base | input | 32 | Ring start address |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Byte accepted at this edge when in_valid is high |
| mem_re | output | 1 | Word read request |
| mem_we | output | 1 | Write request |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte enables for a write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after mem_re |
| overrun | output | 1 | Sticky flag: a frame was dropped for lack of a free descriptor |

## Verification
The bench sends four kinds of frame.
- A short frame checks packing into byte lanes and a status word carrying both frame markers.
- A frame exactly one buffer long tells a full buffer that ends the frame apart from one that spills into the next descriptor.
- A frame longer than one buffer checks how the markers are split and checks wrap back to the start address.
- A frame sent into a descriptor still owned by software checks the drop path and that the overrun flag is sticky.

A stray byte outside a frame, and turning the receiver off and on while the ring is partly used, show that byte counting and the ring position restart where the requirements say.

// File: rtl/rxr_pkg.sv
// Shared constants and types for the receive descriptor ring writer.
// Assumes 32-bit descriptor words and byte addressing.
package rxr_pkg;
    localparam int LEN_W       = 14; // width of the status length field
    localparam int SOF_BIT     = 14; // status: first buffer of a frame
    localparam int EOF_BIT     = 15; // status: last buffer of a frame
    localparam int OWN_BIT     = 0;  // word 0: software owns descriptor
    localparam int WRAP_BIT    = 1;  // word 0: last descriptor in ring
    localparam int DESC_STRIDE = 8;  // bytes per descriptor
    localparam int STAT_OFS    = 4;  // byte offset of status word

    typedef enum logic [2:0] {
        ST_OFF,
        ST_FETCH,
        ST_WAIT,
        ST_READY,
        ST_BUSY,
        ST_WB_STAT,
        ST_WB_ADDR
    } rx_state_t;
endpackage

// File: rtl/rxr_ring_ptr.sv
// Ring position register: holds the ring start and the current descriptor
// address. Assumes load and advance are never high together.
module rxr_ring_ptr
    import rxr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic          wrap,
    input  logic [AW-1:0] base_in,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] ALIGN_MASK = ~(AW'(DESC_STRIDE - 1));

    logic [AW-1:0] start_q;

    // Capture ring start on enable, then step or wrap per descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            ptr     <= '0;
        end else if (load) begin
            start_q <= base_in & ALIGN_MASK;
            ptr     <= base_in & ALIGN_MASK;
        end else if (advance) begin
            ptr <= wrap ? start_q : ptr + AW'(DESC_STRIDE);
        end
    end
endmodule

// File: rtl/rxr_buf_fill.sv
// Buffer fill tracker: counts bytes placed in the current buffer and notes
// whether its first byte opened a frame and whether a byte closed one.
// Assumes clear and take are never high together.
module rxr_buf_fill #(
    parameter int BUF_BYTES = 1536,
    parameter int CW        = $clog2(BUF_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          take,
    input  logic          take_sof,
    input  logic          take_eof,
    output logic [CW-1:0] count,
    output logic          sof_seen,
    output logic          eof_seen,
    output logic          last_slot
);
    assign last_slot = (count == CW'(BUF_BYTES - 1));

    // Byte count and frame markers for the buffer being filled.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count    <= '0;
            sof_seen <= 1'b0;
            eof_seen <= 1'b0;
        end else if (take) begin
            count    <= count + 1'b1;
            if (count == '0) sof_seen <= take_sof;
            eof_seen <= take_eof;
        end
    end
endmodule

// File: rtl/rxr_ctrl.sv
// Sequencer: fetches descriptors, routes stream bytes to the buffer or to
// the drop path, and orders the two write-back cycles. Assumes the read
// data of a fetch is valid in the cycle after the request.
module rxr_ctrl
    import rxr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_enable,
    input  logic      in_valid,
    input  logic      in_sof,
    input  logic      in_eof,
    input  logic      desc_owned,
    input  logic      last_slot,
    output rx_state_t st,
    output logic      in_ready,
    output logic      take,
    output logic      ptr_load,
    output logic      ptr_adv,
    output logic      fill_clr,
    output logic      desc_latch,
    output logic      overrun
);
    rx_state_t nxt;
    logic      in_frame;
    logic      frame_byte;

    assign frame_byte = in_valid && (in_sof || in_frame);
    assign in_ready   = (st == ST_READY) || (st == ST_BUSY);
    assign take       = (st == ST_READY) && frame_byte;
    assign ptr_load   = (st == ST_OFF) && rx_enable;
    assign ptr_adv    = (st == ST_WB_ADDR);
    assign fill_clr   = ptr_adv || ptr_load;
    assign desc_latch = (st == ST_WAIT);

    // Next-state selection.
    always_comb begin
        nxt = st;
        unique case (st)
            ST_OFF:     nxt = ST_FETCH;
            ST_FETCH:   nxt = ST_WAIT;
            ST_WAIT:    nxt = desc_owned ? ST_BUSY : ST_READY;
            ST_READY:   if (take && (in_eof || last_slot)) nxt = ST_WB_STAT;
            ST_BUSY: begin
                if (frame_byte && !in_eof)      nxt = ST_BUSY;
                else if (!in_valid && in_frame) nxt = ST_BUSY;
                else                            nxt = ST_FETCH;
            end
            ST_WB_STAT: nxt = ST_WB_ADDR;
            ST_WB_ADDR: nxt = ST_FETCH;
            default:    nxt = ST_OFF;
        endcase
        if (!rx_enable) nxt = ST_OFF;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= nxt;
    end

    // Open-frame tracking across buffers and across the drop path.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_enable)       in_frame <= 1'b0;
        else if (in_ready && frame_byte) in_frame <= !in_eof;
    end

    // Sticky drop flag, cleared while the receiver is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_enable)             overrun <= 1'b0;
        else if (st == ST_BUSY && frame_byte) overrun <= 1'b1;
    end
endmodule

// File: rtl/rx_desc_ring_writer.sv
// Receive descriptor ring writer top: ties the sequencer, ring position and
// fill tracker to one memory request port. Assumes the memory completes
// writes in the request cycle and returns read data one cycle later.
module rx_desc_ring_writer
    import rxr_pkg::*;
#(
    parameter int BUF_BYTES = 1536
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_enable,
    input  logic [31:0] ring_base,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_sof,
    input  logic        in_eof,
    output logic        in_ready,
    output logic        mem_re,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        overrun
);
    localparam int CW = $clog2(BUF_BYTES + 1);

    rx_state_t      st;
    logic           take, ptr_load, ptr_adv, fill_clr, desc_latch;
    logic           sof_seen, eof_seen, last_slot;
    logic [CW-1:0]  count;
    logic [31:0]    ptr;
    logic [31:0]    buf_base;
    logic           desc_wrap;
    logic [31:0]    byte_addr;
    logic [31:0]    status_word;

    rxr_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_enable  (rx_enable),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_eof     (in_eof),
        .desc_owned (mem_rdata[OWN_BIT]),
        .last_slot  (last_slot),
        .st         (st),
        .in_ready   (in_ready),
        .take       (take),
        .ptr_load   (ptr_load),
        .ptr_adv    (ptr_adv),
        .fill_clr   (fill_clr),
        .desc_latch (desc_latch),
        .overrun    (overrun)
    );

    rxr_ring_ptr #(.AW(32)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ptr_load),
        .advance (ptr_adv),
        .wrap    (desc_wrap),
        .base_in (ring_base),
        .ptr     (ptr)
    );

    rxr_buf_fill #(.BUF_BYTES(BUF_BYTES), .CW(CW)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (fill_clr),
        .take      (take),
        .take_sof  (in_sof),
        .take_eof  (in_eof),
        .count     (count),
        .sof_seen  (sof_seen),
        .eof_seen  (eof_seen),
        .last_slot (last_slot)
    );

    // Hold buffer address and wrap flag of the fetched descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_base  <= '0;
            desc_wrap <= 1'b0;
        end else if (desc_latch) begin
            buf_base  <= {mem_rdata[31:2], 2'b00};
            desc_wrap <= mem_rdata[WRAP_BIT];
        end
    end

    assign byte_addr = buf_base + 32'(count);

    // Pack markers and length into the status word.
    always_comb begin
        status_word            = '0;
        status_word[LEN_W-1:0] = LEN_W'(count);
        status_word[SOF_BIT]   = sof_seen;
        status_word[EOF_BIT]   = eof_seen;
    end

    // Drive the memory port from the sequencer state.
    always_comb begin
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = '0;
        mem_wdata = '0;
        unique case (st)
            ST_FETCH: begin
                mem_re   = 1'b1;
                mem_addr = ptr;
            end
            ST_READY: begin
                mem_we    = take;
                mem_addr  = {byte_addr[31:2], 2'b00};
                mem_be    = 4'b0001 << byte_addr[1:0];
                mem_wdata = {4{in_data}};
            end
            ST_WB_STAT: begin
                mem_we    = 1'b1;
                mem_addr  = ptr + 32'(STAT_OFS);
                mem_be    = 4'hF;
                mem_wdata = status_word;
            end
            ST_WB_ADDR: begin
                mem_we    = 1'b1;
                mem_addr  = ptr;
                mem_be    = 4'hF;
                mem_wdata = {buf_base[31:2], desc_wrap, 1'b1};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rxr_checker.sv
// Port-level protocol checks for the receive descriptor ring writer,
// attached to every instance by the bind below.
module rxr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_enable,
    input logic        in_valid,
    input logic        in_ready,
    input logic        mem_re,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic [31:0] mem_wdata,
    input logic        overrun
);
    // R1: one cycle after a low enable the block is quiet
    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> (!in_ready && !mem_we && !mem_re && !overrun));

    // R3: a full-word write to word 0 always returns ownership
    a_r3_owner_on_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_be == 4'hF && !mem_addr[2]) |-> mem_wdata[0]);

    // R4: status write is followed at once by word 0 of the same descriptor
    a_r4_status_then_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_be == 4'hF && mem_addr[2]) |=>
        (mem_we && mem_be == 4'hF && mem_addr == $past(mem_addr) - 32'd4));

    // R5: byte writes use one lane and only on an accepted byte
    a_r5_one_lane_per_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_be != 4'hF) |->
        ($countones(mem_be) == 1 && in_valid && in_ready));

    // R5: a read and a write are never issued together
    a_r5_no_port_clash: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> !mem_we);

    // R8: overrun holds while the receiver stays on
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && rx_enable) |=> overrun);
endmodule

bind rx_desc_ring_writer rxr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_enable (rx_enable),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .overrun   (overrun)
);

// File: tb/rx_desc_ring_writer_test.sv
`timescale 1ns/1ps
// Bench: memory model plus a behavioural ring model (ownership array, ring
// index, sticky drop flag) checked after each frame and on every write.
module rx_desc_ring_writer_test;
    localparam int BUFB  = 16;
    localparam int NDESC = 4;
    localparam logic [31:0] RING = 32'h100;
    localparam logic [31:0] BUF0 = 32'h200;

    logic        clk = 0, rst_n = 0, rx_enable = 0;
    logic [31:0] ring_base = RING;
    logic        in_valid = 0, in_sof = 0, in_eof = 0;
    logic [7:0]  in_data = 0;
    logic        in_ready, mem_re, mem_we, overrun;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;

    logic [31:0] mem [0:255];
    int  errors = 0, checks = 0;
    int  m_ptr = 0;
    bit  m_own [NDESC];
    bit  exp_over = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    rx_desc_ring_writer #(.BUF_BYTES(BUFB)) uut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .ring_base(ring_base),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_ready(in_ready), .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .overrun(overrun)
    );

    function automatic logic [31:0] buf_of(int i);
        return BUF0 + 32'(i * 32);
    endfunction

    function automatic int dword(int i);
        return (RING >> 2) + 2 * i;
    endfunction

    task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory model; also checks every byte write against the ownership view (R3).
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr[9:2]];
        if (mem_we) begin
            if (mem_be != 4'hF) begin
                int idx;
                idx = int'((mem_addr - BUF0) >> 5);
                checks++;
                if (idx < 0 || idx >= NDESC || mem[dword(idx)][0]) begin
                    errors++;
                    $display("FAIL R3 byte write addr actual=%h expected=free buffer", mem_addr);
                end
            end
            for (int l = 0; l < 4; l++)
                if (mem_be[l]) mem[mem_addr[9:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
        end
    end

    task automatic send_byte(logic [7:0] b, logic s, logic e);
        @(negedge clk);
        in_valid = 1; in_data = b; in_sof = s; in_eof = e;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic send_frame(int len, logic [7:0] first);
        for (int k = 0; k < len; k++)
            send_byte(first + 8'(k), k == 0, k == len - 1);
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0;
        repeat (10) @(negedge clk);
    endtask

    // Reference model of where a frame lands and what each descriptor holds.
    task automatic expect_frame(int len, logic [7:0] first);
        int  got = 0;
        bit  first_chunk = 1;
        while (got < len) begin
            int i, n, bad;
            bit last;
            logic [31:0] st_exp, a;
            i = m_ptr;
            if (m_own[i]) begin exp_over = 1; break; end // R8 drop
            n = (len - got > BUFB) ? BUFB : len - got;
            last = (got + n == len);
            check_eq("R3", "word0", mem[dword(i)],
                     buf_of(i) | ((i == NDESC - 1) ? 32'h2 : 32'h0) | 32'h1);
            st_exp = (32'(last) << 15) | (32'(first_chunk) << 14) | 32'(n); // R4 R6
            check_eq("R4", "status", mem[dword(i) + 1], st_exp);
            bad = 0;
            for (int k = 0; k < n; k++) begin
                a = buf_of(i) + 32'(k);
                if (mem[a[9:2]][8*a[1:0] +: 8] !== first + 8'(got + k)) bad++;
            end
            check_eq("R5", "bad bytes", 32'(bad), 32'd0);
            m_own[i] = 1;
            m_ptr = (i == NDESC - 1) ? 0 : i + 1; // R7 wrap to start
            got += n;
            first_chunk = 0;
        end
        check_eq("R8", "overrun", {31'd0, overrun}, {31'd0, exp_over});
    endtask

    task automatic sw_free(int i);
        @(negedge clk);
        mem[dword(i)][0] = 1'b0;
        m_own[i] = 0;
    endtask

    initial begin
        for (int w = 0; w < 256; w++) mem[w] = 32'h0;
        for (int i = 0; i < NDESC; i++) begin
            mem[dword(i)]     = buf_of(i) | ((i == NDESC - 1) ? 32'h2 : 32'h0);
            mem[dword(i) + 1] = 32'hFFFF_FFFF;
            m_own[i] = 0;
        end
        mem_rdata = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check_eq("R1", "in_ready", {31'd0, in_ready}, 0);
        check_eq("R1", "mem_we", {31'd0, mem_we}, 0);
        check_eq("R1", "mem_re", {31'd0, mem_re}, 0);
        check_eq("R1", "overrun", {31'd0, overrun}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        check_eq("R1", "mem_re while off", {31'd0, mem_re}, 0);
        rx_enable = 1;
        repeat (4) @(negedge clk);

        send_frame(5, 8'h10);            // short frame
        expect_frame(5, 8'h10);

        send_byte(8'hEE, 0, 0);          // R9 stray byte
        @(negedge clk); in_valid = 0;
        repeat (6) @(negedge clk);
        check_eq("R9", "desc1 status untouched", mem[dword(1) + 1], 32'hFFFF_FFFF);
        check_eq("R9", "buf1 untouched", mem[buf_of(1) >> 2], 32'h0);

        send_frame(16, 8'h40);           // exactly one buffer
        expect_frame(16, 8'h40);

        send_frame(20, 8'h80);           // R6 spans two, R7 wrap on desc3
        expect_frame(20, 8'h80);

        send_frame(3, 8'hC0);            // R8 desc0 still software-owned
        expect_frame(3, 8'hC0);
        check_eq("R8", "desc0 status kept", mem[dword(0) + 1], 32'h0000_C005);

        sw_free(0);
        repeat (6) @(negedge clk);
        send_frame(4, 8'hD0);            // R7 ring returned to start
        expect_frame(4, 8'hD0);

        rx_enable = 0;                   // R1 R8 off clears flag
        repeat (2) @(negedge clk);
        check_eq("R8", "overrun cleared", {31'd0, overrun}, 0);
        check_eq("R1", "in_ready off", {31'd0, in_ready}, 0);
        exp_over = 0;

        sw_free(0);
        rx_enable = 1;                   // R2 restart at ring start
        m_ptr = 0;
        repeat (4) @(negedge clk);
        send_frame(6, 8'hE0);
        expect_frame(6, 8'hE0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule